// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block sits on the host side of a serial successive-approximation converter whose port runs as a clocked slave. A single request carries a channel number and a small mode field. The block then runs one full conversion sequence without further help. It shifts a five-bit control word into the converter under a transmit frame strobe, then raises a convert-start pulse. It waits out the worst-case conversion time, then opens a receive frame and clocks in sixteen bits.

The received frame contains a leading zero bit, an echo of the three address bits, and a twelve-bit result. The block returns the requested channel, the result and an error flag through a valid/ready output. The flag is set when the echo does not match the request or the leading bit is not zero. All serial timing is counted in system clock cycles and set by parameters. The serial clock, both frame strobes and the convert-start line are driven from registers.

Top module: `adc_host_ctrl`

## Requirements
- R1: The control word is `{reqChan, reqMode}`, with the channel in its top three bits, and is sent most significant bit first on `ctlSerOut`. That output changes only together with a rising serial clock edge, so it is stable across every falling edge.
- R2: `txSyncN` goes low while `sclkOut` is still high, before the first falling edge. Exactly five falling edges occur while it is low, and it returns high afterwards. `sclkOut` never falls while both frame strobes are high, and the two strobes are never low together.
- R3: `rxSyncN` goes low while `sclkOut` is high. Exactly sixteen falling edges occur while it is low. `datSerIn` is sampled once at each of them, and the first bit sampled is frame bit 15.
- R4: Frame bit 15 is the leading bit, bits 14:12 are the echoed address and bits 11:0 are the result. The result is presented on `resData` unchanged.
- R5: `convStart` is low when idle. It gives exactly one high pulse of `CONV_PULSE` cycles per sequence, rising only after the transmit frame has closed and never during a frame.
- R6: `rxSyncN` falls no sooner than `CONV_WAIT` cycles after the rising edge of `convStart`.
- R7: `sclkOut` idles high, and each high phase and each low phase lasts at least `SCLK_HALF` cycles.
- R8: `resValid` stays high with `resData`, `resChan` and `resErr` unchanged until `resReady` is seen. After that handshake `busy` and `resValid` are low on the next cycle.
- R9: `resErr` is 1 when the leading bit is 1 or the echoed address differs from the requested channel, and is 0 otherwise.
- R10: `busy` is high from the cycle after a request is accepted until the output handshake. A `reqValid` seen while `busy` is high starts no sequence and does not change the pending channel.
- R11: After reset `busy`, `resValid`, `convStart` are 0 and `sclkOut`, `txSyncN`, `rxSyncN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a sequence when idle |
| reqChan | input | 3 | Channel to convert |
| reqMode | input | 2 | Low bits of the control word |
| busy | output | 1 | A sequence is in progress |
| sclkOut | output | 1 | Serial clock to the converter |
| txSyncN | output | 1 | Transmit frame strobe, active low |
| rxSyncN | output | 1 | Receive frame strobe, active low |
| ctlSerOut | output | 1 | Serial control data to the converter |
| datSerIn | input | 1 | Serial frame data from the converter |
| convStart | output | 1 | Convert-start pulse, active on rising edge |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Result accepted |
| resChan | output | 3 | Channel that was requested |
| resData | output | 12 | Conversion result |
| resErr | output | 1 | Address echo or leading bit mismatch |

## Verification
The bench builds the block with `SCLK_HALF` of 2, `CONV_PULSE` of 3 and `CONV_WAIT` of 20. A whole sequence then takes about a hundred cycles, so many sequences fit in a short run. Even with these short timings, a two-cycle half period still shows any phase that is one cycle short against the minimum. The wait is long enough to tell a correctly delayed receive frame from one that starts as soon as the pulse ends. A converter model in the bench captures the control word and replays a chosen frame. With it, each echo mismatch, each leading-bit fault and each result pattern can be set up directly.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_CONV,
    ST_READ,
    ST_OUT
  } ctlState_t;

  typedef struct packed {
    logic loadReq;
    logic txShift;
    logic rxSample;
  } dpStrobe_t;

endpackage

// File: rtl/adc_host_ctl.sv
module adc_host_ctl
  import adc_host_pkg::*;
#(
  parameter int SCLK_HALF  = 2,
  parameter int CONV_PULSE = 3,
  parameter int CONV_WAIT  = 20,
  parameter int CTRL_BITS  = 5,
  parameter int FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       resReady,
  output logic       busy,
  output logic       resValid,
  output logic       sclkOut,
  output logic       txSyncN,
  output logic       rxSyncN,
  output logic       convStart,
  output dpStrobe_t  st
);

  localparam int PH_W   = $clog2(2 * SCLK_HALF);
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam int WAIT_W = $clog2(CONV_WAIT);
  localparam logic [PH_W-1:0]   PH_FALL    = PH_W'(SCLK_HALF - 1);
  localparam logic [PH_W-1:0]   PH_LAST    = PH_W'(2 * SCLK_HALF - 1);
  localparam logic [BIT_W-1:0]  TX_LAST    = BIT_W'(CTRL_BITS - 1);
  localparam logic [BIT_W-1:0]  RX_LAST    = BIT_W'(FRAME_BITS - 1);
  localparam logic [WAIT_W-1:0] PULSE_LAST = WAIT_W'(CONV_PULSE - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST  = WAIT_W'(CONV_WAIT - 1);

  ctlState_t         state;
  logic [PH_W-1:0]   phase;
  logic [BIT_W-1:0]  bitCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [BIT_W-1:0]  lastBit;

  assign lastBit  = (state == ST_WRITE) ? TX_LAST : RX_LAST;
  assign busy     = (state != ST_IDLE);
  assign resValid = (state == ST_OUT);

  always_comb begin
    st          = '0;
    st.loadReq  = (state == ST_IDLE) && reqValid;
    st.txShift  = (state == ST_WRITE) && (phase == PH_LAST) && (bitCnt != lastBit);
    st.rxSample = (state == ST_READ) && (phase == PH_FALL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= '0;
      bitCnt    <= '0;
      waitCnt   <= '0;
      sclkOut   <= 1'b1;
      txSyncN   <= 1'b1;
      rxSyncN   <= 1'b1;
      convStart <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_WRITE;
            phase   <= '0;
            bitCnt  <= '0;
            sclkOut <= 1'b1;
            txSyncN <= 1'b0;
          end
        end
        ST_WRITE, ST_READ: begin
          phase <= phase + 1'b1;
          if (phase == PH_FALL) sclkOut <= 1'b0;
          if (phase == PH_LAST) begin
            phase   <= '0;
            sclkOut <= 1'b1;
            if (bitCnt == lastBit) begin
              if (state == ST_WRITE) begin
                state     <= ST_CONV;
                txSyncN   <= 1'b1;
                convStart <= 1'b1;
                waitCnt   <= '0;
              end else begin
                state   <= ST_OUT;
                rxSyncN <= 1'b1;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_CONV: begin
          waitCnt <= waitCnt + 1'b1;
          if (waitCnt == PULSE_LAST) convStart <= 1'b0;
          if (waitCnt == WAIT_LAST) begin
            state   <= ST_READ;
            rxSyncN <= 1'b0;
            phase   <= '0;
            bitCnt  <= '0;
          end
        end
        ST_OUT: begin
          if (resReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  frames_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!txSyncN && !rxSyncN));

  // R5
  conv_outside_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStart) |-> (txSyncN && rxSyncN));

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> resValid);

  // R10
  busy_until_handshake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(resValid && resReady)) |=> busy);

endmodule

// File: rtl/adc_host_dp.sv
module adc_host_dp
  import adc_host_pkg::*;
#(
  parameter int CTRL_BITS  = 5,
  parameter int FRAME_BITS = 16,
  parameter int ADDR_BITS  = 3,
  parameter int RES_BITS   = 12
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpStrobe_t                       st,
  input  logic [ADDR_BITS-1:0]            reqChan,
  input  logic [CTRL_BITS-ADDR_BITS-1:0]  reqMode,
  input  logic                            datSerIn,
  output logic                            ctlSerOut,
  output logic [ADDR_BITS-1:0]            resChan,
  output logic [RES_BITS-1:0]             resData,
  output logic                            resErr
);

  localparam int LEAD_BITS = FRAME_BITS - RES_BITS - ADDR_BITS;
  localparam int LEAD_LSB  = RES_BITS + ADDR_BITS;

  logic [CTRL_BITS-1:0]  txReg;
  logic [FRAME_BITS-1:0] rxReg;
  logic [ADDR_BITS-1:0]  chanReg;
  logic [ADDR_BITS-1:0]  echoAddr;
  logic [LEAD_BITS-1:0]  leadBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      rxReg   <= '0;
      chanReg <= '0;
    end else begin
      if (st.loadReq) begin
        txReg   <= {reqChan, reqMode};
        chanReg <= reqChan;
      end else if (st.txShift) begin
        txReg <= {txReg[CTRL_BITS-2:0], 1'b0};
      end
      if (st.rxSample) rxReg <= {rxReg[FRAME_BITS-2:0], datSerIn};
    end
  end

  assign echoAddr  = rxReg[RES_BITS +: ADDR_BITS];
  assign leadBits  = rxReg[LEAD_LSB +: LEAD_BITS];
  assign ctlSerOut = txReg[CTRL_BITS-1];
  assign resChan   = chanReg;
  assign resData   = rxReg[RES_BITS-1:0];
  assign resErr    = (|leadBits) || (echoAddr != chanReg);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.loadReq && (st.txShift || st.rxSample)));

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int SCLK_HALF  = 2,
  parameter int CONV_PULSE = 3,
  parameter int CONV_WAIT  = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqChan,
  input  logic [1:0]  reqMode,
  output logic        busy,
  output logic        sclkOut,
  output logic        txSyncN,
  output logic        rxSyncN,
  output logic        ctlSerOut,
  input  logic        datSerIn,
  output logic        convStart,
  output logic        resValid,
  input  logic        resReady,
  output logic [2:0]  resChan,
  output logic [11:0] resData,
  output logic        resErr
);

  dpStrobe_t strobes;

  adc_host_ctl #(
    .SCLK_HALF(SCLK_HALF), .CONV_PULSE(CONV_PULSE), .CONV_WAIT(CONV_WAIT),
    .CTRL_BITS(5), .FRAME_BITS(16)
  ) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .resReady(resReady),
    .busy(busy), .resValid(resValid), .sclkOut(sclkOut), .txSyncN(txSyncN),
    .rxSyncN(rxSyncN), .convStart(convStart), .st(strobes)
  );

  adc_host_dp #(
    .CTRL_BITS(5), .FRAME_BITS(16), .ADDR_BITS(3), .RES_BITS(12)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(strobes), .reqChan(reqChan), .reqMode(reqMode),
    .datSerIn(datSerIn), .ctlSerOut(ctlSerOut), .resChan(resChan),
    .resData(resData), .resErr(resErr)
  );

  // R2
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkOut) |-> (!txSyncN || !rxSyncN));

  // R1
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclkOut) && !txSyncN) |-> $stable(ctlSerOut));

  // R8
  payload_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> $stable({resData, resChan, resErr}));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> $stable(resChan));

endmodule

// File: tb/sim_adc_host_ctrl.sv
module sim_adc_host_ctrl;

  localparam int HALF  = 2;
  localparam int PULSE = 3;
  localparam int WAITC = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqChan = '0;
  logic [1:0] reqMode = '0;
  logic resReady = 1'b0;
  logic datSerIn = 1'b0;
  logic busy, sclkOut, txSyncN, rxSyncN, ctlSerOut, convStart, resValid, resErr;
  logic [2:0] resChan;
  logic [11:0] resData;

  int passCnt = 0;
  int totalCnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_host_ctrl #(.SCLK_HALF(HALF), .CONV_PULSE(PULSE), .CONV_WAIT(WAITC)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqMode(reqMode), .busy(busy), .sclkOut(sclkOut), .txSyncN(txSyncN),
    .rxSyncN(rxSyncN), .ctlSerOut(ctlSerOut), .datSerIn(datSerIn),
    .convStart(convStart), .resValid(resValid), .resReady(resReady),
    .resChan(resChan), .resData(resData), .resErr(resErr)
  );

  // converter model and timing monitor
  logic pSclk = 1'b1, pTx = 1'b1, pRx = 1'b1, pConv = 1'b0, pDout = 1'b0;
  logic [4:0] gotCtrl = '0;
  logic [15:0] frame = '0;
  logic tbLead = 1'b0;
  logic [2:0] tbXor = '0;
  logic [11:0] tbData = '0;
  int txFalls = 0, rxFalls = 0, rxIdx = 0, strayFalls = 0, doutMoves = 0;
  int runLen = 0, minHi = 1000, minLo = 1000;
  int pulses = 0, convRun = 0, lastPulse = 0, sinceConv = 0, lastGap = 0, convInFrame = 0;
  int rxBeforeConv = 0, syncOnLowClk = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sclkOut != pSclk) begin
        if (pSclk) begin if (runLen < minHi) minHi = runLen; end
        else begin if (runLen < minLo) minLo = runLen; end
        runLen = 1;
      end else runLen++;
      if (pTx && !txSyncN && !sclkOut) syncOnLowClk++;
      if (pRx && !rxSyncN && !sclkOut) syncOnLowClk++;
      if (pSclk && !sclkOut) begin
        if (!txSyncN) begin
          gotCtrl = {gotCtrl[3:0], ctlSerOut};
          txFalls++;
          if (ctlSerOut != pDout) doutMoves++;
        end else if (!rxSyncN) rxFalls++;
        else strayFalls++;
      end
      if (!pConv && convStart) begin
        pulses++; convRun = 1; sinceConv = 0;
        if (!txSyncN || !rxSyncN) convInFrame++;
      end else begin
        sinceConv++;
        if (convStart) convRun++;
        if (pConv && !convStart) lastPulse = convRun;
      end
      if (pRx && !rxSyncN) begin
        if (pulses == 0) rxBeforeConv++;
        lastGap = sinceConv;
        frame = {tbLead, gotCtrl[4:2] ^ tbXor, tbData};
        rxIdx = 0;
        datSerIn = frame[15];
      end else if (!rxSyncN && !pSclk && sclkOut) begin
        rxIdx++;
        if (rxIdx < 16) datSerIn = frame[15 - rxIdx];
      end
    end
    pSclk = sclkOut; pTx = txSyncN; pRx = rxSyncN; pConv = convStart; pDout = ctlSerOut;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic clearStats();
    txFalls = 0; rxFalls = 0; pulses = 0; lastPulse = 0; lastGap = 0;
  endtask

  task automatic runSeq(input logic [2:0] ch, input logic [1:0] md, input logic [11:0] dat,
                        input logic lead, input logic [2:0] xr, input bit intrude,
                        input int holdCyc);
    logic expErr;
    logic [11:0] d0;
    expErr = lead || (xr != 3'b000);
    clearStats();
    tbLead = lead; tbXor = xr; tbData = dat;
    @(negedge clk);
    reqChan = ch; reqMode = md; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (intrude) begin
      repeat (4) @(negedge clk);
      reqChan = ~ch; reqMode = ~md; reqValid = 1'b1;
      repeat (10) @(negedge clk);
      reqValid = 1'b0; reqChan = ch;
    end
    while (!resValid) @(negedge clk);
    check(gotCtrl == {ch, md}, "R1 control word", gotCtrl, {ch, md});
    check(txFalls == 5, "R2 falls in tx frame", txFalls, 5);
    check(rxFalls == 16, "R3 falls in rx frame", rxFalls, 16);
    check(resData == dat, "R4 result", resData, dat);
    check(resChan == ch, "R10 channel kept", resChan, ch);
    check(resErr == expErr, "R9 error flag", resErr, expErr);
    check(pulses == 1 && lastPulse == PULSE, "R5 convert pulse", lastPulse, PULSE);
    check(lastGap >= WAITC, "R6 conversion wait", lastGap, WAITC);
    d0 = resData;
    for (int i = 0; i < holdCyc; i++) begin
      @(negedge clk);
      check(resValid && resData == d0 && resChan == ch, "R8 hold", resData, d0);
    end
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check(!busy && !resValid, "R8 handshake ends", {busy, resValid}, 0);
    repeat (10) @(negedge clk);
    check(!busy && txFalls == 5, "R10 no extra sequence", txFalls, 5);
  endtask

  task automatic testReset();
    check(!busy && !resValid && !convStart, "R11 reset low outputs",
          {busy, resValid, convStart}, 0);
    check(sclkOut && txSyncN && rxSyncN, "R11 reset high outputs",
          {sclkOut, txSyncN, rxSyncN}, 7);
  endtask

  task automatic testBasic();
    runSeq(3'd5, 2'b10, 12'hA5C, 1'b0, 3'b000, 1'b0, 0);
    runSeq(3'd0, 2'b01, 12'hFFF, 1'b0, 3'b000, 1'b0, 0);
    runSeq(3'd7, 2'b11, 12'h000, 1'b0, 3'b000, 1'b0, 0);
  endtask

  task automatic testMismatch();
    runSeq(3'd2, 2'b00, 12'h123, 1'b0, 3'b100, 1'b0, 0);
    runSeq(3'd6, 2'b01, 12'h800, 1'b1, 3'b000, 1'b0, 0);
    runSeq(3'd1, 2'b10, 12'h001, 1'b0, 3'b001, 1'b0, 0);
  endtask

  task automatic testIgnoreAndHold();
    runSeq(3'd2, 2'b11, 12'h5A5, 1'b0, 3'b000, 1'b1, 0);
    runSeq(3'd4, 2'b00, 12'h3C3, 1'b0, 3'b000, 1'b0, 6);
  endtask

  task automatic testTiming();
    check(minHi >= HALF, "R7 sclk high time", minHi, HALF);
    check(minLo >= HALF, "R7 sclk low time", minLo, HALF);
    check(strayFalls == 0, "R2 no falls outside frames", strayFalls, 0);
    check(syncOnLowClk == 0, "R2 R3 strobe falls with sclk high", syncOnLowClk, 0);
    check(doutMoves == 0, "R1 data stable at falling edge", doutMoves, 0);
    check(convInFrame == 0 && rxBeforeConv == 0, "R5 pulse outside frames",
          convInFrame, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testBasic();
    testMismatch();
    testIgnoreAndHold();
    testTiming();
    done = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

endmodule